// File: doc/BRIEF.md
# ADC Register Front End

This block is the bus-facing register set of an on-chip analog-to-digital converter. A CPU reaches it through a byte bus with an address, write data, a write strobe, a read strobe and read data. It holds eight registers: control and status, a clock setting, a main result split into high and low bytes, three additional low result bytes and a scan control byte. A write to the control register selects the input channel and the conversion mode, and then starts the converter. Results come back from an abstract converter model and are latched here. Finished conversions are reported either through a polled completion flag or through an interrupt line.

The converter side uses a pulse handshake, not a valid/ready stream. `conv_start` is a single-cycle request and `conv_done` is a single-cycle response that carries `conv_result`. Neither side can apply back-pressure. A new start makes the converter discard whatever it was doing. The block only ever accepts the first done pulse after a start. If the bus write path and a done pulse meet in the same cycle, the write takes precedence. Selecting channel code 5'h1F turns the converter off. The first conversion after it is turned back on only serves to settle the analog front end, so the block drops that result and requests another conversion.

Top module: `adc_regfront`

## Requirements
- R1: After reset, the control register reads 8'h1F, every other register reads 8'h00, `irq` is 0 and no start pulse is issued.
- R2: The registers are at byte offsets from `BASE_ADDR` (which must be aligned to 8):
  - 0 is control;
  - 1 is clock setting (read/write, driven on `clk_cfg`);
  - 2 is result high;
  - 3 is result low 0;
  - 4 to 6 are result low 1 to 3;
  - 7 is scan control (read/write, bit 0 = scan enable).
- R3: In the control register, bit 7 is the completion flag, bit 6 is the interrupt enable, bit 5 is continuous mode and bits 4:0 are the channel. Bit 7 is read-only and a written value there is ignored.
- R4: A control write with a channel other than 5'h1F produces `conv_start` in the cycle after the write, with `conv_chan` equal to the written field, and aborts any conversion in progress. A write of 5'h1F issues no start and drops any running conversion.
- R5: With interrupt enable at 0, each accepted conversion sets the completion flag. With interrupt enable at 1, the flag reads 0.
- R6: The completion flag clears on a control write, on a clock-setting write, and on a read of offsets 3 to 6. A read of offset 2 leaves it set. A completion in the same cycle as a read or clock-setting write wins over the clear.
- R7: With interrupt enable at 1, each accepted conversion raises `irq`. `irq` clears on a read of offset 2 or 3, or on a control write.
- R8: In continuous mode with scan disabled, a new start is issued in the cycle after each accepted conversion. Without continuous mode, or with scan enabled, the converter goes idle after one result.
- R9: The first done pulse after the channel leaves 5'h1F (reset included) is discarded: results, flag and `irq` are unchanged, and a new start is issued in the next cycle.
- R10: An accepted result is stored only on a done pulse. With scan disabled it goes to slot 0: result high holds bits above 7, zero-extended, and result low 0 holds bits 7:0. With scan enabled, the low byte goes to the slot given by channel bits 1:0, and slot 0 keeps the full value.
- R11: Reads outside the eight offsets return 8'h00. Writes to result offsets or unmapped addresses change nothing.
- R12: A done pulse with no conversion outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read; read side effects occur at its clock edge |
| bus_rdata | output | 8 | Read data for the addressed register, 0 when unmapped |
| irq | output | 1 | Conversion interrupt |
| clk_cfg | output | 8 | Clock setting register value for the converter |
| conv_start | output | 1 | One-cycle start request |
| conv_chan | output | 5 | Channel for the conversion |
| conv_done | input | 1 | One-cycle completion from the converter |
| conv_result | input | RES_W | Conversion result, valid with conv_done |

## Verification
The bench builds the block with a 10-bit result, so result high carries two live bits and its zero-extension is visible. It places `BASE_ADDR` at 8'h40, so addresses 8'h3F and 8'h48 fall on either side of the map and exercise the unmapped path. A scoreboard queues each expected read value, and the bench counts start pulses. Together these cover the settle discard, aborts, continuous restarts and the flag and interrupt clear rules.

// File: rtl/adc_regfront_pkg.sv
package adc_regfront_pkg;
  localparam int CHAN_W = 5;
  localparam logic [CHAN_W-1:0] CHAN_OFF = 5'h1F;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int OFS_W = 3;

  typedef enum logic [OFS_W-1:0] {
    OFS_CTRL = 3'd0,
    OFS_CLK  = 3'd1,
    OFS_RHI  = 3'd2,
    OFS_RLO0 = 3'd3,
    OFS_RLO1 = 3'd4,
    OFS_RLO2 = 3'd5,
    OFS_RLO3 = 3'd6,
    OFS_SCAN = 3'd7
  } reg_ofs_e;

  typedef struct packed {
    logic              ie;
    logic              cont;
    logic [CHAN_W-1:0] chan;
  } ctrl_t;
endpackage

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_regfront_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [CHAN_W-1:0] new_chan,
  input  logic              cont,
  input  logic              scan_en,
  input  logic              done_in,
  output logic              start_o,
  output logic              valid_done_o
);
  logic busy_q, settle_q, off_q, start_q;
  logic is_off;

  assign is_off       = (new_chan == CHAN_OFF);
  assign valid_done_o = busy_q & done_in & ~settle_q & ~wr_ctrl;
  assign start_o      = start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      settle_q <= 1'b0;
      off_q    <= 1'b1;
      start_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (wr_ctrl) begin
        off_q    <= is_off;
        busy_q   <= ~is_off;
        start_q  <= ~is_off;
        settle_q <= ~is_off & (off_q | settle_q);
      end else if (busy_q && done_in) begin
        if (settle_q) begin
          settle_q <= 1'b0;
          start_q  <= 1'b1;
        end else if (cont && !scan_en) begin
          start_q <= 1'b1;
        end else begin
          busy_q <= 1'b0;
        end
      end
    end
  end

  // R4: a live channel write starts the converter one cycle later
  assert_start_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !is_off) |=> start_q);
  // R4: the off code never starts and leaves nothing outstanding
  assert_quiet_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && is_off) |=> (!start_q && !busy_q));
  // R9: the settling result is dropped and a fresh start follows
  assert_settle_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && done_in && settle_q && !wr_ctrl) |=> (start_q && !settle_q));
  // R8: continuous mode restarts immediately
  assert_cont_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_done_o && cont && !scan_en) |=> start_q);
  // R12: nothing starts while idle without a write
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !wr_ctrl) |=> !start_q);
endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adc_regfront_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic [6:0] wdata,
  input  logic       valid_done,
  input  logic       clr_flag_evt,
  input  logic       clr_irq_evt,
  output ctrl_t      ctrl_o,
  output logic       flag_vis,
  output logic       irq_o
);
  ctrl_t ctrl_q;
  logic  flag_q, irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '{ie: 1'b0, cont: 1'b0, chan: CHAN_OFF};
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_t'(wdata);
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (valid_done && !ctrl_q.ie)  flag_q <= 1'b1;
      else if (clr_flag_evt)         flag_q <= 1'b0;
      if (valid_done && ctrl_q.ie)   irq_q  <= 1'b1;
      else if (clr_irq_evt)          irq_q  <= 1'b0;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign flag_vis = flag_q & ~ctrl_q.ie;
  assign irq_o    = irq_q;

  // R5: the flag only rises on an accepted conversion
  assert_flag_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !valid_done) |=> !flag_q);
  // R6: clearing events drop the flag unless a completion coincides
  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl || (clr_flag_evt && !valid_done)) |=> !flag_q);
  // R7: interrupt only rises on an accepted conversion
  assert_irq_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && !valid_done) |=> !irq_q);
  // R7: interrupt clears on result-0 read or control write
  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl || (clr_irq_evt && !valid_done)) |=> !irq_q);
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store
  import adc_regfront_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           valid_done,
  input  logic [RES_W-1:0]               result,
  input  logic                           scan_en,
  input  logic [SLOT_W-1:0]              chan_slot,
  output logic [7:0]                     res_hi,
  output logic [NUM_SLOTS-1:0][7:0]      res_lo
);
  logic [RES_W-1:0]  full_q;
  logic [SLOT_W-1:0] slot_sel;

  assign slot_sel = scan_en ? chan_slot : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) full_q <= '0;
    else if (valid_done && slot_sel == '0) full_q <= result;
  end

  assign res_hi    = 8'(full_q >> 8);
  assign res_lo[0] = full_q[7:0];

  for (genvar k = 1; k < NUM_SLOTS; k++) begin : g_slot
    logic [7:0] lo_q;
    always_ff @(posedge clk) begin
      if (!rst_n) lo_q <= '0;
      else if (valid_done && slot_sel == SLOT_W'(k)) lo_q <= result[7:0];
    end
    assign res_lo[k] = lo_q;
  end

  // R10: main result holds between accepted conversions
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_done |=> $stable(full_q));
  // R10: an accepted slot-0 result is captured as presented
  assert_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_done && slot_sel == '0) |=> (full_q == $past(result)));
endmodule

// File: rtl/adc_regfront.sv
module adc_regfront
  import adc_regfront_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40,
  parameter int                RES_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic [7:0]        clk_cfg,
  output logic              conv_start,
  output logic [4:0]        conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result
);
  logic     hit;
  reg_ofs_e ofs;
  logic     wr_ctrl, wr_clk, wr_scan, rd_lo_any, rd_res0;
  logic     valid_done, flag_vis, scan_en;
  logic [7:0] clk_q, scan_q, res_hi;
  logic [NUM_SLOTS-1:0][7:0] res_lo;
  ctrl_t    ctrl;

  assign hit = (bus_addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
  assign ofs = reg_ofs_e'(bus_addr[OFS_W-1:0]);

  assign wr_ctrl   = bus_wr & hit & (ofs == OFS_CTRL);
  assign wr_clk    = bus_wr & hit & (ofs == OFS_CLK);
  assign wr_scan   = bus_wr & hit & (ofs == OFS_SCAN);
  assign rd_lo_any = bus_rd & hit & (ofs == OFS_RLO0 || ofs == OFS_RLO1 ||
                                     ofs == OFS_RLO2 || ofs == OFS_RLO3);
  assign rd_res0   = bus_rd & hit & (ofs == OFS_RHI || ofs == OFS_RLO0);
  assign scan_en   = scan_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_q  <= '0;
      scan_q <= '0;
    end else begin
      if (wr_clk)  clk_q  <= bus_wdata;
      if (wr_scan) scan_q <= bus_wdata;
    end
  end

  adc_ctrl_reg u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ctrl      (wr_ctrl),
    .wdata        (bus_wdata[6:0]),
    .valid_done   (valid_done),
    .clr_flag_evt (wr_clk | rd_lo_any),
    .clr_irq_evt  (rd_res0),
    .ctrl_o       (ctrl),
    .flag_vis     (flag_vis),
    .irq_o        (irq)
  );

  adc_conv_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ctrl      (wr_ctrl),
    .new_chan     (bus_wdata[CHAN_W-1:0]),
    .cont         (ctrl.cont),
    .scan_en      (scan_en),
    .done_in      (conv_done),
    .start_o      (conv_start),
    .valid_done_o (valid_done)
  );

  adc_result_store #(.RES_W(RES_W)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_done (valid_done),
    .result     (conv_result),
    .scan_en    (scan_en),
    .chan_slot  (ctrl.chan[SLOT_W-1:0]),
    .res_hi     (res_hi),
    .res_lo     (res_lo)
  );

  assign clk_cfg   = clk_q;
  assign conv_chan = ctrl.chan;

  always_comb begin
    bus_rdata = 8'h00;
    if (hit) begin
      case (ofs)
        OFS_CTRL: bus_rdata = {flag_vis, ctrl.ie, ctrl.cont, ctrl.chan};
        OFS_CLK:  bus_rdata = clk_q;
        OFS_RHI:  bus_rdata = res_hi;
        OFS_RLO0: bus_rdata = res_lo[0];
        OFS_RLO1: bus_rdata = res_lo[1];
        OFS_RLO2: bus_rdata = res_lo[2];
        OFS_RLO3: bus_rdata = res_lo[3];
        OFS_SCAN: bus_rdata = scan_q;
        default:  bus_rdata = 8'h00;
      endcase
    end
  end

  // R11: unmapped addresses read as zero
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (bus_rdata == 8'h00));
  // R3: the flag bit never reads set while interrupts are enabled
  assert_flag_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ofs == OFS_CTRL && ctrl.ie) |-> !bus_rdata[7]);
endmodule

// File: tb/adc_regfront_tb_top.sv
module adc_regfront_tb_top;
  localparam int ADDR_W = 8;
  localparam int RES_W  = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0]        bus_wdata = '0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]        bus_rdata;
  logic              irq, conv_start, conv_done = 1'b0;
  logic [7:0]        clk_cfg;
  logic [4:0]        conv_chan;
  logic [RES_W-1:0]  conv_result = '0;

  int checks = 0, errors = 0, start_cnt = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  adc_regfront #(.ADDR_W(ADDR_W), .BASE_ADDR(8'h40), .RES_W(RES_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq),
    .clk_cfg(clk_cfg), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_result(conv_result)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // start pulse monitor
  always @(negedge clk) if (rst_n && conv_start) start_cnt++;

  // read monitor: pops expected values from the scoreboard
  initial forever begin
    @(negedge clk);
    #2;
    if (bus_rd) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
      else check(tag_q.pop_front(), int'(bus_rdata), int'(exp_q.pop_front()));
    end
  end

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic finish_conv(input logic [RES_W-1:0] r);
    @(negedge clk);
    conv_done = 1'b1; conv_result = r;
    @(negedge clk);
    conv_done = 1'b0;
    #1;
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h40, 8'h1F, "R1 ctrl reset");
    rd(8'h41, 8'h00, "R1 clk reset");
    rd(8'h42, 8'h00, "R1 hi reset");
    rd(8'h43, 8'h00, "R1 lo0 reset");
    rd(8'h44, 8'h00, "R1 lo1 reset");
    rd(8'h47, 8'h00, "R1 scan reset");
    check("R1 irq", irq, 0);
    check("R1 start count", start_cnt, 0);
    // R11 unmapped
    rd(8'h48, 8'h00, "R11 above map");
    rd(8'h3F, 8'h00, "R11 below map");
    // R4 start, R9 settle discard
    wr(8'h40, 8'h03);
    check("R4 start after write", start_cnt, 1);
    check("R4 channel", conv_chan, 3);
    finish_conv(10'h155);
    check("R9 restart after settle", start_cnt, 2);
    rd(8'h40, 8'h03, "R9 flag untouched");
    rd(8'h43, 8'h00, "R9 result untouched");
    // R5/R6/R10 normal result
    finish_conv(10'h2A5);
    check("R8 single mode idles", start_cnt, 2);
    rd(8'h40, 8'h83, "R5 flag set");
    rd(8'h42, 8'h02, "R10 high byte");
    rd(8'h40, 8'h83, "R6 high read keeps flag");
    rd(8'h43, 8'hA5, "R10 low byte");
    rd(8'h40, 8'h03, "R6 low read clears flag");
    // R12 stray done
    finish_conv(10'h0FF);
    rd(8'h43, 8'hA5, "R12 stray done result");
    rd(8'h40, 8'h03, "R12 stray done flag");
    check("R12 no start", start_cnt, 2);
    // R11 ignored writes
    wr(8'h43, 8'h77);
    wr(8'h48, 8'h55);
    rd(8'h43, 8'hA5, "R11 result write ignored");
    rd(8'h42, 8'h02, "R11 high unchanged");
    // R3 read-only flag bit
    wr(8'h40, 8'h83);
    check("R3 start", start_cnt, 3);
    rd(8'h40, 8'h03, "R3 bit7 write ignored");
    finish_conv(10'h1C3);
    rd(8'h40, 8'h83, "R5 flag set again");
    wr(8'h41, 8'h05);
    rd(8'h40, 8'h03, "R6 clock write clears flag");
    rd(8'h41, 8'h05, "R2 clock register");
    check("R2 clk_cfg", clk_cfg, 8'h05);
    // R7 interrupt mode
    wr(8'h40, 8'h44);
    check("R7 start", start_cnt, 4);
    finish_conv(10'h300);
    check("R7 irq set", irq, 1);
    rd(8'h40, 8'h44, "R5 flag masked with ie");
    rd(8'h44, 8'h00, "R7 lo1 read");
    check("R7 irq kept by lo1 read", irq, 1);
    rd(8'h43, 8'h00, "R10 lo0 of 300");
    check("R7 irq cleared by lo0 read", irq, 0);
    rd(8'h42, 8'h03, "R10 high of 300");
    wr(8'h40, 8'h44);
    finish_conv(10'h011);
    check("R7 irq set again", irq, 1);
    wr(8'h40, 8'h44);
    check("R7 irq cleared by ctrl write", irq, 0);
    check("R7 start count", start_cnt, 6);
    finish_conv(10'h012);
    check("R7 irq set third", irq, 1);
    rd(8'h42, 8'h00, "R10 high of 012");
    check("R7 irq cleared by high read", irq, 0);
    // R8 continuous
    wr(8'h40, 8'h25);
    check("R8 start", start_cnt, 7);
    finish_conv(10'h101);
    check("R8 restart 1", start_cnt, 8);
    finish_conv(10'h102);
    check("R8 restart 2", start_cnt, 9);
    rd(8'h43, 8'h02, "R10 continuous update");
    // scan enable blocks continuous, routes to slot 1
    wr(8'h47, 8'h01);
    rd(8'h47, 8'h01, "R2 scan register");
    finish_conv(10'h0AB);
    check("R8 scan stops continuous", start_cnt, 9);
    rd(8'h44, 8'hAB, "R10 scan slot 1");
    rd(8'h43, 8'h02, "R10 slot 0 kept");
    // R4 off code
    wr(8'h40, 8'h1F);
    check("R4 off no start", start_cnt, 9);
    wr(8'h47, 8'h00);
    finish_conv(10'h0CC);
    rd(8'h43, 8'h02, "R4 off done ignored");
    rd(8'h40, 8'h1F, "R4 off ctrl");
    // R9 settle after off
    wr(8'h40, 8'h06);
    check("R4 restart from off", start_cnt, 10);
    finish_conv(10'h0EE);
    check("R9 settle restart", start_cnt, 11);
    rd(8'h43, 8'h02, "R9 settle discarded");
    finish_conv(10'h0EF);
    rd(8'h43, 8'hEF, "R10 after settle");
    // R4 abort
    wr(8'h40, 8'h06);
    wr(8'h40, 8'h07);
    check("R4 abort restarts", start_cnt, 13);
    check("R4 abort channel", conv_chan, 7);
    finish_conv(10'h055);
    rd(8'h43, 8'h55, "R4 result after abort");
    check("R4 single after abort", start_cnt, 13);
    repeat (3) @(negedge clk);
    report();
  end
endmodule